// File: doc/BRIEF.md
# Saturating Element Narrowing Clamp

This block sits after an integer execution unit in a vector datapath. Each element result arrives already computed at the wider of the source and destination element widths. The block carries it as a 65-bit two's complement value, so that the full unsigned 64-bit range and every negative value both fit. It reduces the value to a destination width picked per element (64, 32, 16 or 8 bits).

When saturation is requested, the value is clamped to the signed or unsigned range of that width rather than wrapped. A per-element overflow flag reports whether the clamp altered the value. That flag depends only on the current element and never reads or sets any accumulated summary state.

Saturation and overflow-enable cannot be combined. When both are requested, the block raises an illegal-instruction flag and produces no result. Without saturation, the element is simply truncated. The logic is combinational, followed by one registered output stage with a valid bit.

Top module: `elem_sat_clamp`

## Requirements
- R1: With saturation on and `in_signed`=0, a value above 2^w-1 yields 2^w-1 (all w low bits set) with `out_ovf`=1, where w is the destination width; `out_value` bits at and above w are always 0.
- R2: With saturation on and `in_signed`=1, a value above 2^(w-1)-1 yields that maximum and a value below -2^(w-1) yields that minimum, both with `out_ovf`=1. The result appears as a w-bit two's complement pattern in the low w bits of `out_value`, with the upper bits 0.
- R3: With saturation on and `in_signed`=0, a negative `in_value` (bit 64 set) yields 0 with `out_ovf`=1.
- R4: With saturation on, a value already inside the selected range passes through unchanged, as its low w bits, with `out_ovf`=0.
- R5: `out_ovf` is 1 exactly when the clamp changed the value. It is 0 at the range limits themselves and 1 one step beyond them.
- R6: `in_width` selects the destination width: 2'b00=64, 2'b01=32, 2'b10=16, 2'b11=8 bits.
- R7: When `in_sat`=1 and `in_ovf_en`=1, `out_illegal`=1, `out_value`=0 and `out_ovf`=0.
- R8: When `in_sat`=0, `out_value` is the low w bits of `in_value` (wrap), with `out_ovf`=0 and `out_illegal`=0, whatever the value of `in_ovf_en`.
- R9: Each accepted element appears one clock after `in_valid`, and `out_valid` is 0 in every other cycle. After reset, `out_valid`, `out_value`, `out_ovf` and `out_illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element present on the inputs |
| in_value | input | 65 | Wide element result, two's complement |
| in_width | input | 2 | Destination width code |
| in_signed | input | 1 | 1 = signed range, 0 = unsigned range |
| in_sat | input | 1 | Saturation requested |
| in_ovf_en | input | 1 | Overflow-enable requested |
| out_valid | output | 1 | Result present on the outputs |
| out_value | output | 64 | Narrowed result, zero above the width |
| out_ovf | output | 1 | Clamp changed this element |
| out_illegal | output | 1 | Saturation combined with overflow-enable |

## Verification
The hardest case to reach is a negative wide value in unsigned mode at the 64-bit destination width. There, the low 64 bits alone look like a large in-range unsigned number, and only bit 64 reveals that the value is negative. The stimulus drives 65-bit values with the top bit set at the 64-bit width. It also drives values exactly at, and one step beyond, each signed and unsigned limit, so that the overflow flag is seen flipping at the boundary.

// File: rtl/sat_pkg.sv
package sat_pkg;
    localparam int unsigned NUM_DW = 4;

    // destination width code; width = full >> code
    typedef enum logic [1:0] {
        DW_FULL    = 2'b00,
        DW_HALF    = 2'b01,
        DW_QUARTER = 2'b10,
        DW_EIGHTH  = 2'b11
    } dw_code_e;
endpackage

// File: rtl/sat_range.sv
module sat_range
    import sat_pkg::*;
#(
    parameter int unsigned MAX_W = 64
) (
    input  dw_code_e                 code_i,
    input  logic                     signed_i,
    output logic signed [MAX_W:0]    lo_o,
    output logic signed [MAX_W:0]    hi_o,
    output logic [MAX_W-1:0]         mask_o
);
    logic [MAX_W-1:0]      mask_c [NUM_DW];
    logic signed [MAX_W:0] umax_c [NUM_DW];
    logic signed [MAX_W:0] smax_c [NUM_DW];
    logic signed [MAX_W:0] smin_c [NUM_DW];

    for (genvar k = 0; k < NUM_DW; k++) begin : g_width
        localparam int unsigned WK = MAX_W >> k;
        assign mask_c[k] = {MAX_W{1'b1}} >> (MAX_W - WK);
        assign umax_c[k] = {1'b0, mask_c[k]};
        assign smax_c[k] = {1'b0, (mask_c[k] >> 1)};
        assign smin_c[k] = ~smax_c[k];
    end

    always_comb begin
        mask_o = mask_c[code_i];
        hi_o   = signed_i ? smax_c[code_i] : umax_c[code_i];
        lo_o   = signed_i ? smin_c[code_i] : '0;
    end

    // R6
    range_order_chk: assert final (lo_o <= hi_o);
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int unsigned MAX_W = 64
) (
    input  logic signed [MAX_W:0] value_i,
    input  logic signed [MAX_W:0] lo_i,
    input  logic signed [MAX_W:0] hi_i,
    input  logic [MAX_W-1:0]      mask_i,
    output logic [MAX_W-1:0]      clamped_o,
    output logic                  hit_o
);
    logic above, below;

    always_comb begin
        above = value_i > hi_i;
        below = value_i < lo_i;
        hit_o = above | below;
        if (above)
            clamped_o = hi_i[MAX_W-1:0] & mask_i;
        else if (below)
            clamped_o = lo_i[MAX_W-1:0] & mask_i;
        else
            clamped_o = value_i[MAX_W-1:0] & mask_i;
    end
endmodule

// File: rtl/elem_sat_clamp.sv
module elem_sat_clamp
    import sat_pkg::*;
#(
    parameter int unsigned MAX_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [MAX_W:0]     in_value,
    input  logic [1:0]         in_width,
    input  logic               in_signed,
    input  logic               in_sat,
    input  logic               in_ovf_en,
    output logic               out_valid,
    output logic [MAX_W-1:0]   out_value,
    output logic               out_ovf,
    output logic               out_illegal
);
    typedef struct packed {
        logic             valid;
        logic [MAX_W-1:0] value;
        logic             ovf;
        logic             ill;
    } out_s;

    out_s state_d, state_q;

    logic signed [MAX_W:0] lo, hi;
    logic [MAX_W-1:0]      mask;
    logic [MAX_W-1:0]      clamped;
    logic                  hit;
    dw_code_e              code;

    assign code = dw_code_e'(in_width);

    sat_range #(.MAX_W(MAX_W)) u_range (
        .code_i   (code),
        .signed_i (in_signed),
        .lo_o     (lo),
        .hi_o     (hi),
        .mask_o   (mask)
    );

    sat_clamp #(.MAX_W(MAX_W)) u_clamp (
        .value_i   (in_value),
        .lo_i      (lo),
        .hi_i      (hi),
        .mask_i    (mask),
        .clamped_o (clamped),
        .hit_o     (hit)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            if (in_sat && in_ovf_en) begin
                state_d.value = '0;
                state_d.ovf   = 1'b0;
                state_d.ill   = 1'b1;
            end else if (in_sat) begin
                state_d.value = clamped;
                state_d.ovf   = hit;
                state_d.ill   = 1'b0;
            end else begin
                state_d.value = in_value[MAX_W-1:0] & mask;
                state_d.ovf   = 1'b0;
                state_d.ill   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid   = state_q.valid;
    assign out_value   = state_q.value;
    assign out_ovf     = state_q.ovf;
    assign out_illegal = state_q.ill;

    // R9
    valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R9
    idle_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7
    illegal_combo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sat && in_ovf_en) |=> (out_illegal && out_value == '0 && !out_ovf));
    // R8
    wrap_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sat) |=> (!out_ovf && !out_illegal));
    // R3
    neg_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sat && !in_ovf_en && !in_signed && in_value[MAX_W])
        |=> (out_value == '0 && out_ovf));
endmodule

// File: tb/sim_elem_sat_clamp.sv
module sim_elem_sat_clamp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [64:0] in_value = '0;
    logic [1:0]  in_width = 2'b00;
    logic        in_signed = 1'b0;
    logic        in_sat = 1'b0;
    logic        in_ovf_en = 1'b0;
    logic        out_valid;
    logic [63:0] out_value;
    logic        out_ovf;
    logic        out_illegal;

    int errors = 0;
    int checks = 0;
    logic [65:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    elem_sat_clamp u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_width(in_width), .in_signed(in_signed), .in_sat(in_sat),
        .in_ovf_en(in_ovf_en), .out_valid(out_valid), .out_value(out_value),
        .out_ovf(out_ovf), .out_illegal(out_illegal)
    );

    // expected {illegal, ovf, value}
    function automatic logic [65:0] model(input logic signed [64:0] v, input logic [1:0] code,
                                          input logic sgn, input logic sat, input logic oe);
        int unsigned w;
        logic [63:0] m;
        logic signed [64:0] hi, lo, c;
        logic ov;
        w = 64 >> code;
        m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        if (sat && oe) return {1'b1, 1'b0, 64'd0};
        if (!sat) return {1'b0, 1'b0, v[63:0] & m};
        if (sgn) begin
            hi = (65'sd1 <<< (w - 1)) - 65'sd1;
            lo = -hi - 65'sd1;
        end else begin
            hi = $signed({1'b0, m});
            lo = 65'sd0;
        end
        ov = 1'b1;
        if (v > hi)      c = hi;
        else if (v < lo) c = lo;
        else begin c = v; ov = 1'b0; end
        return {1'b0, ov, c[63:0] & m};
    endfunction

    task automatic send(input logic signed [64:0] v, input logic [1:0] code,
                        input logic sgn, input logic sat, input logic oe, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_value = v; in_width = code;
        in_signed = sgn; in_sat = sat; in_ovf_en = oe;
        exp_q.push_back(model(v, code, sgn, sat, oe));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: R9 valid timing and scoreboard compare
    initial begin
        logic pv;
        logic [65:0] e;
        string t;
        forever begin
            @(posedge clk);
            pv = in_valid;
            #5;
            if (rst_n) begin
                checks++;
                if (out_valid !== pv) begin
                    errors++;
                    $display("FAIL R9 out_valid actual=%b expected=%b", out_valid, pv);
                end
                if (out_valid) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R9 unexpected result actual=%h expected=none", out_value);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if ({out_illegal, out_ovf, out_value} !== e) begin
                            errors++;
                            $display("FAIL %s actual=%b/%b/%h expected=%b/%b/%h", t,
                                     out_illegal, out_ovf, out_value, e[65], e[64], e[63:0]);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({out_valid, out_illegal, out_ovf, out_value} !== 67'd0) begin
            errors++;
            $display("FAIL R9 reset actual=%b/%b/%b/%h expected=0/0/0/0",
                     out_valid, out_illegal, out_ovf, out_value);
        end

        send(65'sd300,   2'b11, 1'b0, 1'b1, 1'b0, "R1 unsigned w8 above");
        send(65'sd70000, 2'b10, 1'b0, 1'b1, 1'b0, "R1 R6 unsigned w16 above");
        send(65'sd200,   2'b11, 1'b0, 1'b1, 1'b0, "R4 unsigned w8 in range");
        idle();
        send(-65'sd5,    2'b01, 1'b0, 1'b1, 1'b0, "R3 unsigned w32 negative");
        send(65'sh1_0000_0000_0000_0001, 2'b00, 1'b0, 1'b1, 1'b0, "R3 unsigned w64 negative");
        send(65'sh0_FFFF_FFFF_FFFF_FFFF, 2'b00, 1'b0, 1'b1, 1'b0, "R4 R6 unsigned w64 max");
        send(65'sd200,   2'b11, 1'b1, 1'b1, 1'b0, "R2 signed w8 above");
        send(-65'sd200,  2'b11, 1'b1, 1'b1, 1'b0, "R2 signed w8 below");
        send(-65'sd1,    2'b10, 1'b1, 1'b1, 1'b0, "R4 signed w16 minus one");
        send(65'sh0_8000_0000_0000_0000, 2'b00, 1'b1, 1'b1, 1'b0, "R2 R6 signed w64 above");
        send(65'sh1_7FFF_FFFF_FFFF_FFFF, 2'b00, 1'b1, 1'b1, 1'b0, "R2 signed w64 below");
        send(65'sd2147483648, 2'b01, 1'b1, 1'b1, 1'b0, "R2 R6 signed w32 above");
        idle();
        idle();
        send(65'sd32767,  2'b10, 1'b1, 1'b1, 1'b0, "R5 signed w16 at max");
        send(65'sd32768,  2'b10, 1'b1, 1'b1, 1'b0, "R5 signed w16 max plus one");
        send(-65'sd32768, 2'b10, 1'b1, 1'b1, 1'b0, "R5 signed w16 at min");
        send(-65'sd32769, 2'b10, 1'b1, 1'b1, 1'b0, "R5 signed w16 min minus one");
        send(65'sd255,    2'b11, 1'b0, 1'b1, 1'b0, "R5 unsigned w8 at max");
        send(65'sd256,    2'b11, 1'b0, 1'b1, 1'b0, "R5 unsigned w8 max plus one");
        send(65'sd300,    2'b11, 1'b0, 1'b1, 1'b1, "R7 sat with overflow enable");
        send(-65'sd7,     2'b00, 1'b1, 1'b1, 1'b1, "R7 signed sat with overflow enable");
        send(65'sh0_0000_0000_0001_2345, 2'b11, 1'b0, 1'b0, 1'b0, "R8 wrap w8");
        send(65'sh0_0000_0000_0001_2345, 2'b10, 1'b1, 1'b0, 1'b1, "R8 wrap w16 overflow enable");
        send(-65'sd1, 2'b01, 1'b1, 1'b0, 1'b0, "R8 wrap w32 minus one");
        send(65'sh1_0000_0000_0000_0042, 2'b00, 1'b0, 1'b0, 1'b0, "R8 wrap w64");
        idle();
        repeat (3) @(negedge clk);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9 pending results actual=%0d expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule